// File: doc/BRIEF.md
# Late-Addend Integer Multiply-Add Pipeline

This block is a fully pipelined integer multiply-add unit. Each cycle it can accept one operation made of two multiplicands, an addend and a destination tag. It returns the low `DATA_W` bits of `a*b + c` three cycles later, together with the tag. There is no back-pressure: an operation presented with the issue strobe is always taken.

The product is built over two register stages: partial products of `a` against slices of `b` come first, then their sum. The addend is not used until the third and last stage. An operation can set the feedback flag. The final stage then takes its addend from the result that completed in the previous cycle, and the `c` operand is ignored. This lets a chain of dependent accumulations run at one per cycle. A value that feeds a multiplicand has to wait for the full three-cycle pipeline.

The unit is meant for the integer side of a scheduler. The scheduler places accumulator-dependent work back to back and spaces multiplicand-dependent work three cycles apart.

Top module: `imad_late_add`

## Requirements
- R1: With the feedback flag clear, the result is `(a*b + c) mod 2^DATA_W`, so overflow wraps silently.
- R2: An operation issued in cycle t raises `res_vld_o` for exactly one cycle, in cycle t+3, with `res_tag_o` equal to the tag it was issued with.
- R3: Operations issued on consecutive cycles complete on consecutive cycles in issue order, one result per cycle.
- R4: With the feedback flag set, the addend is the result that completed in the cycle before this operation's final stage, which is the result of the operation issued one cycle earlier, and `op_c_i` is ignored. A chain of N such operations issued back to back delivers its last result N+2 cycles after the first issue.
- R5: With the feedback flag set and no result completed in the previous cycle, the addend is zero.
- R6: `res_data_o` can be presented as a multiplicand in the same cycle it appears, so a multiplicand-dependent chain runs at one operation every 3 cycles with correct values.
- R7: A synchronous active-low reset flushes every in-flight operation. After the reset edge, `res_vld_o` is 0 and `res_data_o` is 0 until a new operation completes.
- R8: In a cycle where no operation completes, `res_vld_o` is 0 and `res_data_o` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| issue_vld_i | input | 1 | Operation present this cycle |
| op_a_i | input | DATA_W | First multiplicand |
| op_b_i | input | DATA_W | Second multiplicand |
| op_c_i | input | DATA_W | Addend operand, used when the feedback flag is clear |
| tag_i | input | TAG_W | Destination tag carried with the operation |
| acc_fb_i | input | 1 | 1: addend is the previous cycle's result (or zero if none) |
| res_vld_o | output | 1 | Result completes this cycle |
| res_data_o | output | DATA_W | Result value, held between completions |
| res_tag_o | output | TAG_W | Tag of the completing operation |

## Verification
The assertions check on every cycle that the three-cycle valid and tag latency holds and that the arithmetic is right in both addend modes: operand addend, previous-result addend and zero addend. They also check that the output holds while idle and that reset flushes the pipe. Some behaviours are visible only in the bench's scenarios. These include the end-to-end timing of a 100-long addend chain, a multiplicand chain closed through the outputs every three cycles, and reset in the middle of a stream of in-flight operations.

// File: rtl/imad_pkg.sv
// Package: shared constants and types for the late-addend multiply-add unit.
// Assumes nothing beyond being compiled before the modules that import it.
package imad_pkg;

    // Number of register stages in front of the final add stage.
    localparam int unsigned PROD_STAGES = 2;

    // Where the final stage takes its addend from.
    typedef enum logic [1:0] {
        ADD_FROM_OPERAND  = 2'd0,
        ADD_FROM_FEEDBACK = 2'd1,
        ADD_ZERO          = 2'd2
    } addend_src_e;

    // Select the addend source from the feedback flag and the result-valid state.
    function automatic addend_src_e pick_addend(input logic fb, input logic prev_vld);
        if (!fb)
            return ADD_FROM_OPERAND;
        else if (prev_vld)
            return ADD_FROM_FEEDBACK;
        else
            return ADD_ZERO;
    endfunction

endpackage

// File: rtl/imad_prod_pipe.sv
// Module: imad_prod_pipe
// Two-stage low-half product pipeline. Stage 1 registers NSEG partial products
// of a against equal slices of b, each already shifted and truncated to DATA_W.
// Stage 2 registers their sum, the low DATA_W bits of a*b.
// Assumes NSEG divides DATA_W. Reset is synchronous and active low.
module imad_prod_pipe #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NSEG   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] prod_o
);
    localparam int unsigned SEG_W = DATA_W / NSEG;

    logic [NSEG-1:0][DATA_W-1:0] pp_d;
    logic [NSEG-1:0][DATA_W-1:0] pp_q;
    logic [DATA_W-1:0]           sum_d;
    logic [DATA_W-1:0]           prod_q;

    // One partial product per slice of b, positioned at its slice offset.
    for (genvar g = 0; g < NSEG; g++) begin : g_pp
        logic [DATA_W-1:0] seg_ext;
        logic [DATA_W-1:0] raw;
        assign seg_ext  = DATA_W'(b_i[g*SEG_W +: SEG_W]);
        assign raw      = a_i * seg_ext;
        assign pp_d[g]  = raw << (g*SEG_W);
    end

    // Stage 1 register: capture all partial products.
    always_ff @(posedge clk) begin
        if (!rst_n) pp_q <= '0;
        else        pp_q <= pp_d;
    end

    // Reduce the partial products to the low product.
    always_comb begin
        sum_d = '0;
        for (int i = 0; i < NSEG; i++) sum_d = sum_d + pp_q[i];
    end

    // Stage 2 register: capture the low product.
    always_ff @(posedge clk) begin
        if (!rst_n) prod_q <= '0;
        else        prod_q <= sum_d;
    end

    assign prod_o = prod_q;

endmodule

// File: rtl/imad_ctl_pipe.sv
// Module: imad_ctl_pipe
// Delay line that carries valid, tag, feedback flag and addend operand
// alongside the product pipeline, DEPTH stages deep, so that every field
// reaches the final stage together with its product.
// Assumes DEPTH >= 1. Reset is synchronous and active low and clears everything.
module imad_ctl_pipe #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned TAG_W  = 5,
    parameter int unsigned DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld_i,
    input  logic [TAG_W-1:0]  tag_i,
    input  logic              fb_i,
    input  logic [DATA_W-1:0] c_i,
    output logic              vld_o,
    output logic [TAG_W-1:0]  tag_o,
    output logic              fb_o,
    output logic [DATA_W-1:0] c_o
);
    localparam int unsigned PW = TAG_W + 1 + DATA_W;

    logic [DEPTH:0]         vld_s;
    logic [DEPTH:0][PW-1:0] pay_s;

    assign vld_s[0] = vld_i;
    assign pay_s[0] = {tag_i, fb_i, c_i};

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        // Advance one stage of control state.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_s[s+1] <= 1'b0;
                pay_s[s+1] <= '0;
            end else begin
                vld_s[s+1] <= vld_s[s];
                pay_s[s+1] <= pay_s[s];
            end
        end
    end

    assign vld_o = vld_s[DEPTH];
    assign {tag_o, fb_o, c_o} = pay_s[DEPTH];

endmodule

// File: rtl/imad_acc_stage.sv
// Module: imad_acc_stage
// Final stage. It adds the finished product to an addend and registers the
// result. The addend is the operand carried down the pipe, or the result
// register itself when the feedback flag is set, or zero when the flag is set
// but no result completed last cycle. The result register holds between completions.
// Reset is synchronous and active low.
module imad_acc_stage
    import imad_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned TAG_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld_i,
    input  logic [TAG_W-1:0]  tag_i,
    input  logic              fb_i,
    input  logic [DATA_W-1:0] c_i,
    input  logic [DATA_W-1:0] prod_i,
    output logic              res_vld_o,
    output logic [DATA_W-1:0] res_o,
    output logic [TAG_W-1:0]  res_tag_o
);
    addend_src_e       src;
    logic [DATA_W-1:0] addend;
    logic [DATA_W-1:0] sum;
    logic              res_vld_q;
    logic [DATA_W-1:0] res_q;
    logic [TAG_W-1:0]  tag_q;

    // Choose the addend for the operation in this stage.
    always_comb begin
        src = pick_addend(fb_i, res_vld_q);
        unique case (src)
            ADD_FROM_OPERAND:  addend = c_i;
            ADD_FROM_FEEDBACK: addend = res_q;
            default:           addend = '0;
        endcase
        sum = prod_i + addend;
    end

    // Result register: update on a completing operation, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_vld_q <= 1'b0;
            res_q     <= '0;
            tag_q     <= '0;
        end else begin
            res_vld_q <= vld_i;
            if (vld_i) begin
                res_q <= sum;
                tag_q <= tag_i;
            end
        end
    end

    assign res_vld_o = res_vld_q;
    assign res_o     = res_q;
    assign res_tag_o = tag_q;

endmodule

// File: rtl/imad_late_add.sv
// Module: imad_late_add (top)
// Three-stage multiply-add with a late addend. Multiplicands enter the product
// pipe at issue. Tag, flag and addend ride the control pipe. The add happens in
// stage 3. Latency is 3 cycles from issue to result. Accumulator feedback costs 1 cycle.
// Assumes the caller spaces multiplicand-dependent issues 3 cycles apart.
module imad_late_add
    import imad_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned TAG_W  = 5,
    parameter int unsigned NSEG   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_vld_i,
    input  logic [DATA_W-1:0] op_a_i,
    input  logic [DATA_W-1:0] op_b_i,
    input  logic [DATA_W-1:0] op_c_i,
    input  logic [TAG_W-1:0]  tag_i,
    input  logic              acc_fb_i,
    output logic              res_vld_o,
    output logic [DATA_W-1:0] res_data_o,
    output logic [TAG_W-1:0]  res_tag_o
);
    logic              s2_vld;
    logic [TAG_W-1:0]  s2_tag;
    logic              s2_fb;
    logic [DATA_W-1:0] s2_c;
    logic [DATA_W-1:0] s2_prod;

    imad_prod_pipe #(.DATA_W(DATA_W), .NSEG(NSEG)) u_prod (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_i    (op_a_i),
        .b_i    (op_b_i),
        .prod_o (s2_prod)
    );

    imad_ctl_pipe #(.DATA_W(DATA_W), .TAG_W(TAG_W), .DEPTH(PROD_STAGES)) u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .vld_i (issue_vld_i),
        .tag_i (tag_i),
        .fb_i  (acc_fb_i),
        .c_i   (op_c_i),
        .vld_o (s2_vld),
        .tag_o (s2_tag),
        .fb_o  (s2_fb),
        .c_o   (s2_c)
    );

    imad_acc_stage #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .vld_i     (s2_vld),
        .tag_i     (s2_tag),
        .fb_i      (s2_fb),
        .c_i       (s2_c),
        .prod_i    (s2_prod),
        .res_vld_o (res_vld_o),
        .res_o     (res_data_o),
        .res_tag_o (res_tag_o)
    );

endmodule

// File: rtl/imad_late_add_chk.sv
// Module: imad_late_add_chk
// Checker bound to imad_late_add. It relates the port values three cycles
// apart to the outputs. A saturating counter keeps the checks quiet until
// three edges have passed since reset.
module imad_late_add_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned TAG_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              issue_vld_i,
    input logic [DATA_W-1:0] op_a_i,
    input logic [DATA_W-1:0] op_b_i,
    input logic [DATA_W-1:0] op_c_i,
    input logic [TAG_W-1:0]  tag_i,
    input logic              acc_fb_i,
    input logic              res_vld_o,
    input logic [DATA_W-1:0] res_data_o,
    input logic [TAG_W-1:0]  res_tag_o
);
    logic [1:0] since_rst;
    logic       warm;

    // Count edges since reset, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n)                 since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end
    assign warm = (since_rst == 2'd3);

    assert_plain_sum_R1: assert property (@(posedge clk) disable iff (!rst_n || !warm)
        res_vld_o && !$past(acc_fb_i, 3) |->
            res_data_o == $past(op_a_i * op_b_i + op_c_i, 3));

    assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n || !warm)
        res_vld_o == $past(issue_vld_i, 3));

    assert_tag_follows_R2: assert property (@(posedge clk) disable iff (!rst_n || !warm)
        res_vld_o |-> res_tag_o == $past(tag_i, 3));

    assert_feedback_sum_R4: assert property (@(posedge clk) disable iff (!rst_n || !warm)
        res_vld_o && $past(acc_fb_i, 3) && $past(res_vld_o) |->
            res_data_o == $past(op_a_i * op_b_i, 3) + $past(res_data_o));

    assert_zero_addend_R5: assert property (@(posedge clk) disable iff (!rst_n || !warm)
        res_vld_o && $past(acc_fb_i, 3) && !$past(res_vld_o) |->
            res_data_o == $past(op_a_i * op_b_i, 3));

    assert_reset_flush_R7: assert property (@(posedge clk)
        !rst_n |=> !res_vld_o && res_data_o == '0);

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n || !warm)
        !res_vld_o |-> $stable(res_data_o));

endmodule

bind imad_late_add imad_late_add_chk #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_chk (.*);

// File: tb/imad_late_add_bench.sv
// Directed bench for imad_late_add. Inputs are driven and outputs sampled on
// the falling edge. An operation driven at falling edge k shows at falling edge k+3.
module imad_late_add_bench;
    localparam int DW = 32;
    localparam int TW = 5;
    localparam time TCK = 20ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          issue_vld_i = 1'b0;
    logic [DW-1:0] op_a_i = '0, op_b_i = '0, op_c_i = '0;
    logic [TW-1:0] tag_i = '0;
    logic          acc_fb_i = 1'b0;
    logic          res_vld_o;
    logic [DW-1:0] res_data_o;
    logic [TW-1:0] res_tag_o;

    int nvec = 0;
    int nerr = 0;

    always #(TCK/2) clk = ~clk;

    imad_late_add #(.DATA_W(DW), .TAG_W(TW)) u_imad_late_add (.*);

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        nvec++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive(input logic v, input logic [DW-1:0] a, b, c, input logic [TW-1:0] t, input logic fb);
        issue_vld_i = v; op_a_i = a; op_b_i = b; op_c_i = c; tag_i = t; acc_fb_i = fb;
    endtask

    task automatic idle();
        drive(1'b0, '0, '0, '0, '0, 1'b0);
    endtask

    // R7: reset state, then a reset in the middle of a stream.
    task automatic t_reset();
        rst_n = 1'b0; idle();
        repeat (4) @(negedge clk);
        chk(res_vld_o == 1'b0, "R7 valid after reset", DW'(res_vld_o), 0);
        chk(res_data_o == '0, "R7 data after reset", res_data_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        drive(1'b1, 32'd7, 32'd9, 32'd1, 5'd3, 1'b0);
        @(negedge clk);
        drive(1'b1, 32'd5, 32'd5, 32'd5, 5'd4, 1'b0);
        @(negedge clk);
        idle(); rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(res_vld_o == 1'b0, "R7 flushed valid", DW'(res_vld_o), 0);
            chk(res_data_o == '0, "R7 flushed data", res_data_o, 0);
        end
    endtask

    // R1 R2 R3 R8: random stream with random bubbles, checked 3 cycles late.
    task automatic t_stream(input int n, input int bubble_pct);
        logic          pv [$];
        logic [DW-1:0] pr [$];
        logic [TW-1:0] pt [$];
        logic [DW-1:0] last;
        last = res_data_o;
        for (int j = 0; j < n + 3; j++) begin
            @(negedge clk);
            if (j >= 3) begin
                logic          ev;
                logic [DW-1:0] er;
                logic [TW-1:0] et;
                ev = pv.pop_front(); er = pr.pop_front(); et = pt.pop_front();
                chk(res_vld_o == ev, "R2 valid at issue+3", DW'(res_vld_o), DW'(ev));
                if (ev) begin
                    chk(res_data_o == er, "R1 a*b+c", res_data_o, er);
                    chk(res_tag_o == et, "R3 tag order", DW'(res_tag_o), DW'(et));
                    last = er;
                end else begin
                    chk(res_data_o == last, "R8 hold when idle", res_data_o, last);
                end
            end
            if (j < n) begin
                logic          v;
                logic [DW-1:0] a, b, c;
                logic [TW-1:0] t;
                v = (($urandom % 100) >= bubble_pct);
                a = $urandom; b = $urandom; c = $urandom; t = TW'($urandom);
                if (j % 7 == 0) begin a = 32'hFFFF_FFFF; b = 32'hFFFF_FFFF; c = 32'hFFFF_FFFF; end
                drive(v, a, b, c, t, 1'b0);
                pv.push_back(v); pr.push_back(a * b + c); pt.push_back(t);
            end else idle();
        end
    endtask

    // R4: 100-long addend chain at one per cycle; c of chained ops is junk.
    task automatic t_addend_chain();
        logic [DW-1:0] acc;
        logic [DW-1:0] exp_q [$];
        int last_seen;
        last_seen = -1;
        for (int j = 0; j < 110; j++) begin
            @(negedge clk);
            if (res_vld_o) begin
                logic [DW-1:0] e;
                e = exp_q.pop_front();
                chk(res_data_o == e, "R4 chained accumulate", res_data_o, e);
                last_seen = j;
            end
            if (j < 100) begin
                logic [DW-1:0] a, b, c;
                a = $urandom; b = $urandom; c = $urandom;
                drive(1'b1, a, b, c, TW'(j), j != 0);
                acc = (j == 0) ? a * b + c : a * b + acc;
                exp_q.push_back(acc);
            end else idle();
        end
        chk(last_seen == 102, "R4 chain of 100 ends 102 cycles after first issue", DW'(last_seen), 32'd102);
        chk(exp_q.size() == 0, "R4 all chain results seen", DW'(exp_q.size()), 0);
    endtask

    // R5: feedback flag with no result in the previous cycle gives zero addend.
    task automatic t_zero_addend();
        repeat (3) @(negedge clk);
        drive(1'b1, 32'd1000, 32'd3, 32'hDEAD_BEEF, 5'd9, 1'b1);
        @(negedge clk); idle();
        repeat (2) @(negedge clk);
        chk(res_vld_o == 1'b1, "R5 result present", DW'(res_vld_o), 1);
        chk(res_data_o == 32'd3000, "R5 zero addend", res_data_o, 32'd3000);
    endtask

    // R6: result fed back into a multiplicand every 3 cycles.
    task automatic t_mult_chain();
        logic [DW-1:0] a, exp;
        a = 32'd3;
        exp = '0;
        @(negedge clk);
        for (int k = 0; k < 10; k++) begin
            if (k != 0) begin
                chk(res_vld_o == 1'b1, "R6 chain result valid", DW'(res_vld_o), 1);
                chk(res_data_o == exp, "R6 chain value", res_data_o, exp);
                a = res_data_o;
            end
            drive(1'b1, a, 32'd5, 32'd2, TW'(k), 1'b0);
            exp = a * 32'd5 + 32'd2;
            @(negedge clk); idle();
            chk(res_vld_o == 1'b0, "R6 no result between chain steps", DW'(res_vld_o), 0);
            @(negedge clk);
            chk(res_vld_o == 1'b0, "R6 no result between chain steps", DW'(res_vld_o), 0);
            @(negedge clk);
        end
        chk(res_data_o == exp, "R6 final chain value", res_data_o, exp);
        idle();
    endtask

    initial begin
        #(TCK * 200000);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        t_reset();
        t_stream(200, 0);
        t_stream(200, 40);
        t_addend_chain();
        t_zero_addend();
        t_mult_chain();
        t_reset();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

endmodule